// File: doc/BRIEF.md
# Sample Phase Timing Programmer

This block programs the sampling and drive timing of a card host interface. A start strobe carries a controller selector (SD or SDIO), a speed-mode code and an optional requested sample phase. When no phase is requested, the block looks up a per-controller, per-mode table. Each table entry holds a drive phase, a sample delay and a window of legal sample phases, and the block uses the midpoint of that window. From the chosen phase and the mode it works out two flags: a shift enable and a sample-delay enable.

It then issues a fixed series of register writes through a single-cycle write port. The interface clock is first switched off and a short wait follows. The block then writes the extended timing word and the shift-enable register, and switches the clock back on with the divider and the delay flag. A long settling wait follows, and a done pulse closes the sequence. Both waits are parameters counted in clock cycles. A selector that names no controller is refused with an error pulse and produces no writes.

Top module: `phase_prog_top`

## Requirements
- R1: After reset, busy_o, done_o, wr_en_o and err_o are all 0.
- R2: Controller codes: 1 is SD, 2 is SDIO, and 0 is reserved, with every entry all zero. Mode codes: 0 is legacy, 5 is SDR50 and 6 is SDR104. Entry values (drive, delay, max, min) include SD/SDR50 = 4,0,11,0, SD/SDR104 = 6,4,15,0 and SDIO/legacy = 7,0,15,15. When phase_req_vld_i is 0, the phase is (max+min)/2 rounded down. Otherwise it is phase_req_i.
- R3: The extended timing word carries the sample phase in bits 20:16, the drive phase in bits 25:21 and the sample delay in bits 30:26. Every other bit is 0.
- R4: The shift-enable register data is 1 in bit 0 only when the mode is 5 or 6 and the phase is in 4..12 inclusive. Otherwise it is 0. All other bits are 0.
- R5: The delay flag is bit 13 of the clock-on word. It is 1 only when the mode is 6 and the phase is in 11..14 inclusive.
- R6: The clock-on word holds 7 in bits 11:8 and 1 in bit 16. Apart from bit 13, every other bit is 0.
- R7: Write select codes are 0 for clock control, 1 for extended timing and 2 for shift enable. An accepted start causes the following writes, in order:
  - a clock-control write of 0 in the cycle after the start edge;
  - WAIT_SHORT cycles with no write;
  - then, in consecutive cycles, the extended timing write, the shift-enable write and the clock-on write.
- R8: done_o is a one-cycle pulse that comes WAIT_LONG+1 cycles after the clock-on write.
- R9: busy_o is 1 from the cycle after an accepted start through the done cycle. A start seen while busy_o is 1 is ignored.
- R10: A start with a controller code of 3 while idle gives a one-cycle err_o pulse in the next cycle. It causes no write, and busy_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| ctrl_sel_i | input | 2 | Controller code |
| speed_mode_i | input | 4 | Speed-mode code |
| phase_req_vld_i | input | 1 | Use phase_req_i instead of the table midpoint |
| phase_req_i | input | 5 | Requested sample phase |
| wr_en_o | output | 1 | Register write strobe |
| wr_sel_o | output | 2 | Register select |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished pulse |
| err_o | output | 1 | Invalid controller pulse |

## Verification
Every result is timed from the edge that samples the start strobe, called edge s:
- The clock-off write and the rise of busy_o are due in cycle s. An err_o pulse for an invalid controller is also due in cycle s.
- The extended timing, shift and clock-on writes are due in cycles s+WAIT_SHORT+1 to s+WAIT_SHORT+3.
- done_o is due in cycle s+WAIT_SHORT+WAIT_LONG+4.

The bench model turns each accepted start into per-cycle expectations keyed by these cycle numbers. It compares every output at each falling edge, so a write that comes one cycle early or late is caught as both a missing and an unexpected write.

// File: rtl/phase_prog_pkg.sv
package phase_prog_pkg;

    localparam int PH_W   = 5;
    localparam int CTRL_W = 2;
    localparam int MODE_W = 4;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 2;

    localparam logic [CTRL_W-1:0] NUM_CTRL = CTRL_W'(3);

    localparam logic [MODE_W-1:0] MODE_SDR50  = MODE_W'(5);
    localparam logic [MODE_W-1:0] MODE_SDR104 = MODE_W'(6);

    localparam logic [PH_W-1:0] SHIFT_LO = PH_W'(4);
    localparam logic [PH_W-1:0] SHIFT_HI = PH_W'(12);
    localparam logic [PH_W-1:0] DLY_LO   = PH_W'(11);
    localparam logic [PH_W-1:0] DLY_HI   = PH_W'(14);

    localparam int EXT_PH_LSB  = 16;
    localparam int EXT_DRV_LSB = 21;
    localparam int EXT_DLY_LSB = 26;

    localparam int CK_DIV_LSB = 8;
    localparam int CK_DIV_W   = 4;
    localparam int CK_DLY_BIT = 13;
    localparam int CK_EN_BIT  = 16;
    localparam logic [CK_DIV_W-1:0] CK_DIV_VAL = CK_DIV_W'(7);

    typedef enum logic [SEL_W-1:0] {
        REG_CLKCTL  = 2'd0,
        REG_EXTTIM  = 2'd1,
        REG_SHIFTEN = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [PH_W-1:0] drv;
        logic [PH_W-1:0] dly;
        logic [PH_W-1:0] ph_max;
        logic [PH_W-1:0] ph_min;
    } tim_entry_t;

    function automatic tim_entry_t mk_entry(input int d, input int s, input int mx, input int mn);
        tim_entry_t e;
        e.drv    = PH_W'(d);
        e.dly    = PH_W'(s);
        e.ph_max = PH_W'(mx);
        e.ph_min = PH_W'(mn);
        return e;
    endfunction

endpackage

// File: rtl/phase_table.sv
module phase_table
    import phase_prog_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [MODE_W-1:0] mode_i,
    output tim_entry_t        entry_o
);

    tim_entry_t sd_ent;
    tim_entry_t sdio_ent;

    // SD controller (code 1)
    always_comb begin
        case (mode_i)
            MODE_W'(0): sd_ent = mk_entry(7, 0, 15, 15);
            MODE_W'(1): sd_ent = mk_entry(6, 0, 4, 4);
            MODE_W'(2): sd_ent = mk_entry(6, 0, 3, 3);
            MODE_W'(3): sd_ent = mk_entry(6, 0, 15, 15);
            MODE_W'(4): sd_ent = mk_entry(6, 0, 2, 2);
            MODE_W'(5): sd_ent = mk_entry(4, 0, 11, 0);
            MODE_W'(6): sd_ent = mk_entry(6, 4, 15, 0);
            default:    sd_ent = '0;
        endcase
    end

    // SDIO controller (code 2)
    always_comb begin
        case (mode_i)
            MODE_W'(0): sdio_ent = mk_entry(7, 0, 15, 15);
            MODE_W'(2): sdio_ent = mk_entry(6, 0, 15, 15);
            MODE_W'(3): sdio_ent = mk_entry(6, 0, 15, 15);
            MODE_W'(4): sdio_ent = mk_entry(6, 0, 0, 0);
            MODE_W'(5): sdio_ent = mk_entry(4, 0, 12, 0);
            MODE_W'(6): sdio_ent = mk_entry(5, 4, 15, 0);
            default:    sdio_ent = '0;
        endcase
    end

    always_comb begin
        case (ctrl_i)
            CTRL_W'(1): entry_o = sd_ent;
            CTRL_W'(2): entry_o = sdio_ent;
            default:    entry_o = '0;
        endcase
    end

endmodule

// File: rtl/phase_calc.sv
module phase_calc
    import phase_prog_pkg::*;
(
    input  tim_entry_t        entry_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              req_vld_i,
    input  logic [PH_W-1:0]   req_i,
    output logic [DATA_W-1:0] ext_word_o,
    output logic [DATA_W-1:0] shift_word_o,
    output logic [DATA_W-1:0] clkon_word_o
);

    logic [PH_W:0]   win_sum;
    logic [PH_W-1:0] dflt_ph;
    logic [PH_W-1:0] phase;
    logic            mid_mode;
    logic            fast_mode;
    logic            shift_en;
    logic            dly_en;

    always_comb begin
        win_sum   = {1'b0, entry_i.ph_max} + {1'b0, entry_i.ph_min};
        dflt_ph   = PH_W'(win_sum >> 1);
        phase     = req_vld_i ? req_i : dflt_ph;
        fast_mode = (mode_i == MODE_SDR104);
        mid_mode  = fast_mode || (mode_i == MODE_SDR50);
        shift_en  = mid_mode  && (phase >= SHIFT_LO) && (phase <= SHIFT_HI);
        dly_en    = fast_mode && (phase >= DLY_LO)   && (phase <= DLY_HI);
    end

    always_comb begin
        ext_word_o = '0;
        ext_word_o[EXT_PH_LSB  +: PH_W] = phase;
        ext_word_o[EXT_DRV_LSB +: PH_W] = entry_i.drv;
        ext_word_o[EXT_DLY_LSB +: PH_W] = entry_i.dly;

        shift_word_o    = '0;
        shift_word_o[0] = shift_en;

        clkon_word_o = '0;
        clkon_word_o[CK_DIV_LSB +: CK_DIV_W] = CK_DIV_VAL;
        clkon_word_o[CK_DLY_BIT] = dly_en;
        clkon_word_o[CK_EN_BIT]  = 1'b1;
    end

endmodule

// File: rtl/phase_seq.sv
module phase_seq
    import phase_prog_pkg::*;
#(
    parameter int WAIT_SHORT = 250,
    parameter int WAIT_LONG  = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ctrl_ok_i,
    input  logic [DATA_W-1:0] ext_word_i,
    input  logic [DATA_W-1:0] shift_word_i,
    input  logic [DATA_W-1:0] clkon_word_i,
    output logic              wr_en_o,
    output logic [SEL_W-1:0]  wr_sel_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int MAX_WAIT = (WAIT_SHORT > WAIT_LONG) ? WAIT_SHORT : WAIT_LONG;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_CLKOFF, S_WAIT_A, S_EXT, S_SHIFT, S_CLKON, S_WAIT_B, S_DONE
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic              err;
        logic [DATA_W-1:0] ext;
        logic [DATA_W-1:0] shift;
        logic [DATA_W-1:0] clkon;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.err = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (ctrl_ok_i) begin
                        r_d.st    = S_CLKOFF;
                        r_d.ext   = ext_word_i;
                        r_d.shift = shift_word_i;
                        r_d.clkon = clkon_word_i;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            S_CLKOFF: begin
                r_d.st  = S_WAIT_A;
                r_d.cnt = CNT_W'(WAIT_SHORT - 1);
            end
            S_WAIT_A: begin
                if (r_q.cnt == '0) r_d.st = S_EXT;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            S_EXT:   r_d.st = S_SHIFT;
            S_SHIFT: r_d.st = S_CLKON;
            S_CLKON: begin
                r_d.st  = S_WAIT_B;
                r_d.cnt = CNT_W'(WAIT_LONG - 1);
            end
            S_WAIT_B: begin
                if (r_q.cnt == '0) r_d.st = S_DONE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= seq_t'('0);
        else        r_q <= r_d;
    end

    always_comb begin
        wr_en_o   = 1'b0;
        wr_sel_o  = REG_CLKCTL;
        wr_data_o = '0;
        case (r_q.st)
            S_CLKOFF: wr_en_o = 1'b1;
            S_EXT: begin
                wr_en_o   = 1'b1;
                wr_sel_o  = REG_EXTTIM;
                wr_data_o = r_q.ext;
            end
            S_SHIFT: begin
                wr_en_o   = 1'b1;
                wr_sel_o  = REG_SHIFTEN;
                wr_data_o = r_q.shift;
            end
            S_CLKON: begin
                wr_en_o   = 1'b1;
                wr_data_o = r_q.clkon;
            end
            default: ;
        endcase
        busy_o = (r_q.st != S_IDLE);
        done_o = (r_q.st == S_DONE);
        err_o  = r_q.err;
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    p_no_write_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_en_o);

    p_err_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o);

    p_ext_then_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_sel_o == REG_EXTTIM) |=> (wr_en_o && wr_sel_o == REG_SHIFTEN));

    p_shift_then_clkon_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_sel_o == REG_SHIFTEN) |=> (wr_en_o && wr_sel_o == REG_CLKCTL));

endmodule

// File: rtl/phase_prog_top.sv
module phase_prog_top
    import phase_prog_pkg::*;
#(
    parameter int WAIT_SHORT = 250,
    parameter int WAIT_LONG  = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CTRL_W-1:0] ctrl_sel_i,
    input  logic [MODE_W-1:0] speed_mode_i,
    input  logic              phase_req_vld_i,
    input  logic [PH_W-1:0]   phase_req_i,
    output logic              wr_en_o,
    output logic [SEL_W-1:0]  wr_sel_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    tim_entry_t        entry;
    logic [DATA_W-1:0] ext_word;
    logic [DATA_W-1:0] shift_word;
    logic [DATA_W-1:0] clkon_word;
    logic              ctrl_ok;

    assign ctrl_ok = (ctrl_sel_i < NUM_CTRL);

    phase_table i_table (
        .ctrl_i  (ctrl_sel_i),
        .mode_i  (speed_mode_i),
        .entry_o (entry)
    );

    phase_calc i_calc (
        .entry_i      (entry),
        .mode_i       (speed_mode_i),
        .req_vld_i    (phase_req_vld_i),
        .req_i        (phase_req_i),
        .ext_word_o   (ext_word),
        .shift_word_o (shift_word),
        .clkon_word_o (clkon_word)
    );

    phase_seq #(
        .WAIT_SHORT (WAIT_SHORT),
        .WAIT_LONG  (WAIT_LONG)
    ) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .ctrl_ok_i    (ctrl_ok),
        .ext_word_i   (ext_word),
        .shift_word_i (shift_word),
        .clkon_word_i (clkon_word),
        .wr_en_o      (wr_en_o),
        .wr_sel_o     (wr_sel_o),
        .wr_data_o    (wr_data_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

    p_clkon_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_sel_o == REG_CLKCTL && wr_data_o != '0) |->
        (wr_data_o[CK_DIV_LSB +: CK_DIV_W] == CK_DIV_VAL && wr_data_o[CK_EN_BIT]));

    p_ext_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_sel_o == REG_EXTTIM) |->
        (wr_data_o[EXT_PH_LSB-1:0] == '0 && !wr_data_o[DATA_W-1]));

endmodule

// File: tb/test_phase_prog_top.sv
module test_phase_prog_top;

    localparam int WS = 3;
    localparam int WL = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  ctrl = '0;
    logic [3:0]  mode = '0;
    logic        req_vld = 1'b0;
    logic [4:0]  req = '0;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        busy, done, err;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int busy_lo = -10;
    int busy_hi = -10;
    bit finished = 0;

    int          exp_sel[int];
    logic [31:0] exp_dat[int];
    bit          exp_done[int];
    bit          exp_err[int];

    always #10 clk = ~clk;

    phase_prog_top #(.WAIT_SHORT(WS), .WAIT_LONG(WL)) i_phase_prog_top (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ctrl_sel_i(ctrl),
        .speed_mode_i(mode), .phase_req_vld_i(req_vld), .phase_req_i(req),
        .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // Stated table entries only (R2)
    function automatic void ref_tab(input int c, input int m, output int d, output int s,
                                    output int mx, output int mn);
        d = 0; s = 0; mx = 0; mn = 0;
        if (c == 1 && m == 5) begin d = 4; mx = 11; end
        else if (c == 1 && m == 6) begin d = 6; s = 4; mx = 15; end
        else if (c == 2 && m == 0) begin d = 7; mx = 15; mn = 15; end
    endfunction

    // Behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) cyc = 0;
        else begin
            cyc = cyc + 1;
            if (start && (cyc - 1 > busy_hi)) begin
                if (ctrl == 2'd3) exp_err[cyc] = 1;
                else begin
                    int d, s, mx, mn, ph;
                    bit sh, dl;
                    ref_tab(ctrl, mode, d, s, mx, mn);
                    ph = req_vld ? int'(req) : (mx + mn) / 2;
                    sh = (mode == 5 || mode == 6) && ph >= 4 && ph <= 12;
                    dl = (mode == 6) && ph >= 11 && ph <= 14;
                    exp_sel[cyc] = 0;          exp_dat[cyc] = 0;
                    exp_sel[cyc+WS+1] = 1;     exp_dat[cyc+WS+1] = (ph << 16) | (d << 21) | (s << 26);
                    exp_sel[cyc+WS+2] = 2;     exp_dat[cyc+WS+2] = 32'(sh);
                    exp_sel[cyc+WS+3] = 0;     exp_dat[cyc+WS+3] = (7 << 8) | (int'(dl) << 13) | (1 << 16);
                    exp_done[cyc+WS+WL+4] = 1;
                    busy_lo = cyc;
                    busy_hi = cyc + WS + WL + 4;
                end
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && cyc > 0) begin
            int k;
            bit ew;
            k = cyc;
            ew = exp_sel.exists(k);
            chk(wr_en == ew, "R7 write strobe", 32'(wr_en), 32'(ew));
            if (ew && wr_en) begin
                chk(wr_sel == 2'(exp_sel[k]), "R7 write select", 32'(wr_sel), 32'(exp_sel[k]));
                if (exp_sel[k] == 1)
                    chk(wr_data == exp_dat[k], "R2 R3 timing word", wr_data, exp_dat[k]);
                else if (exp_sel[k] == 2)
                    chk(wr_data == exp_dat[k], "R4 shift enable", wr_data, exp_dat[k]);
                else
                    chk(wr_data == exp_dat[k], "R5 R6 clock control", wr_data, exp_dat[k]);
            end
            chk(done == exp_done.exists(k), "R8 done pulse", 32'(done), 32'(exp_done.exists(k)));
            chk(err == exp_err.exists(k), "R10 error pulse", 32'(err), 32'(exp_err.exists(k)));
            chk(busy == (k >= busy_lo && k <= busy_hi), "R9 busy", 32'(busy),
                32'(k >= busy_lo && k <= busy_hi));
        end
    end

    task automatic go(input int c, input int m, input bit v, input int r);
        ctrl = 2'(c); mode = 4'(m); req_vld = v; req = 5'(r);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic settle();
        repeat (WS + WL + 8) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy, "R1 busy", 32'(busy), 0);
        chk(!done, "R1 done", 32'(done), 0);
        chk(!wr_en, "R1 wr_en", 32'(wr_en), 0);
        chk(!err, "R1 err", 32'(err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        go(1, 5, 0, 0);  settle();   // R2 default midpoint 5, R4 shift on
        go(1, 6, 0, 0);  settle();   // R2 default 7
        go(1, 6, 1, 12); settle();   // R4 R5 both on
        go(1, 6, 1, 13); settle();   // R5 only
        go(1, 6, 1, 11); settle();
        go(1, 6, 1, 15); settle();
        go(1, 6, 1, 3);  settle();
        go(1, 5, 1, 12); settle();   // R5 off outside SDR104
        go(1, 5, 1, 13); settle();
        go(1, 5, 1, 4);  settle();
        go(2, 0, 0, 0);  settle();   // R2 SDIO legacy, phase 15
        go(2, 0, 1, 8);  settle();   // R4 off in legacy mode
        go(0, 6, 0, 0);  settle();   // R2 reserved zeros
        go(0, 6, 1, 31); settle();   // R3 full phase field
        go(3, 6, 0, 0);  settle();   // R10 invalid controller

        // R9 start while busy is ignored
        go(1, 6, 1, 12);
        @(negedge clk);
        go(1, 5, 1, 9);
        settle();

        // R9 start in the done cycle ignored, next cycle accepted
        go(2, 0, 0, 0);
        while (!done) @(negedge clk);
        go(1, 6, 1, 14);
        go(1, 5, 0, 0);
        settle();

        finish_run();
    end

endmodule